// File: doc/BRIEF.md
# CAN Bit-Time Stamp Counter

This block keeps a free-running 16-bit time base that advances once for every bit time recognised on a CAN bus. A bit-timing unit, which lies outside this block, supplies a one-cycle tick per bus bit. The frame engine supplies a strobe in the acknowledge slot, a flag saying whether the frame went through, and the index of the message buffer the frame belongs to.

When a frame completes with success, the current count is written as that frame's time stamp. The write goes out as a one-cycle capture strobe that carries the buffer index and the captured value.

Buffer 0 is the synchronisation buffer. When synchronisation is enabled and a buffer-0 frame completes, the block captures the count first and then clears the counter. Every node that sees the same buffer-0 frame therefore restarts its time base at the same bus position.

Top module: `bit_stamp_timer`

## Requirements
- R1: While rst_ni is low, count_o is 0 and cap_we_o is 0.
- R2: At each clock edge where bit_tick_i is 1 and no sync clear applies, count_o rises by exactly one. Without a tick it holds its value.
- R3: The counter wraps from 16'hFFFF to 16'h0000 on a tick and raises no flag.
- R4: When ack_slot_i and frame_ok_i are both 1 in a cycle and buf_idx_i is below NUM_BUF (15), cap_we_o is 1 in the next cycle only. In that cycle cap_idx_o equals buf_idx_i, and cap_data_o equals the count_o value seen in the strobe cycle, before any tick of that edge.
- R5: With frame_ok_i at 0, an ack_slot_i strobe produces no capture write and leaves the count unchanged apart from its normal ticking.
- R6: A successful frame on buffer 0 with sync_en_i at 1 sets count_o to 0 after the capture edge, even when bit_tick_i is 1 in the same cycle.
- R7: A successful frame on buffer 0 with sync_en_i at 0 is captured like any other buffer and does not clear the counter.
- R8: A successful frame on a buffer other than 0 never clears the counter, whatever sync_en_i is.
- R9: A successful frame whose buf_idx_i is NUM_BUF or more (for example 15) produces no capture write and no clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-cycle pulse per recognised bus bit time |
| ack_slot_i | input | 1 | One-cycle strobe in the acknowledge slot |
| frame_ok_i | input | 1 | Frame sent or received successfully |
| buf_idx_i | input | 4 | Message buffer the frame belongs to |
| sync_en_i | input | 1 | Enables the buffer-0 counter clear |
| count_o | output | 16 | Current time-base value |
| cap_we_o | output | 1 | Time-stamp write strobe |
| cap_idx_o | output | 4 | Buffer that receives the time stamp |
| cap_data_o | output | 16 | Time-stamp value |

## Verification
The assertions check on every cycle that:
- the counter steps by one or holds;
- a sync-qualified buffer-0 completion always leaves zero, even against a simultaneous tick;
- every qualified strobe yields exactly one write with the prior count and index;
- a write never appears without a strobe.

The bench's scenarios cover what a single-cycle property cannot: the full 65536-tick wrap, and long sequences in which stamps taken after a sync clear measure from the new origin. They also confirm that disabled sync, failed frames and out-of-range indices leave the observed count stream intact.

// File: rtl/stamp_pkg.sv
package stamp_pkg;
  localparam int unsigned CNT_W   = 16;
  localparam int unsigned IDX_W   = 4;
  localparam int unsigned NUM_BUF = 15;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [IDX_W-1:0] idx_t;

  typedef struct packed {
    logic we;
    idx_t idx;
    cnt_t data;
  } cap_t;
endpackage

// File: rtl/stamp_qualify.sv
module stamp_qualify
  import stamp_pkg::*;
#(
  parameter int unsigned NB = NUM_BUF,
  parameter int unsigned IW = IDX_W
) (
  input  logic          ack_slot_i,
  input  logic          frame_ok_i,
  input  logic [IW-1:0] buf_idx_i,
  input  logic          sync_en_i,
  output logic          take_o,
  output logic          clear_o
);
  localparam int unsigned SLOTS = 1 << IW;
  logic idx_ok;

  generate
    if (NB >= SLOTS) begin : g_full
      assign idx_ok = 1'b1;
    end else begin : g_range
      assign idx_ok = (int'(buf_idx_i) < NB);
    end
  endgenerate

  assign take_o  = ack_slot_i & frame_ok_i & idx_ok;
  assign clear_o = take_o & sync_en_i & (buf_idx_i == '0);
endmodule

// File: rtl/stamp_counter.sv
module stamp_counter
  import stamp_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         clear_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)     cnt_d = '0;   // clear beats tick
    else if (tick_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/stamp_capture.sv
module stamp_capture
  import stamp_pkg::*;
#(
  parameter int unsigned W  = CNT_W,
  parameter int unsigned IW = IDX_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic [IW-1:0] idx_i,
  input  logic [W-1:0]  cnt_i,
  output logic          we_o,
  output logic [IW-1:0] idx_o,
  output logic [W-1:0]  data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o   <= 1'b0;
      idx_o  <= '0;
      data_o <= '0;
    end else begin
      we_o <= take_i;
      if (take_i) begin
        idx_o  <= idx_i;
        data_o <= cnt_i;
      end
    end
  end
endmodule

// File: rtl/bit_stamp_timer.sv
module bit_stamp_timer
  import stamp_pkg::*;
#(
  parameter int unsigned W  = CNT_W,
  parameter int unsigned IW = IDX_W,
  parameter int unsigned NB = NUM_BUF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_tick_i,
  input  logic          ack_slot_i,
  input  logic          frame_ok_i,
  input  logic [IW-1:0] buf_idx_i,
  input  logic          sync_en_i,
  output logic [W-1:0]  count_o,
  output logic          cap_we_o,
  output logic [IW-1:0] cap_idx_o,
  output logic [W-1:0]  cap_data_o
);
  logic take, clear;

  stamp_qualify #(.NB(NB), .IW(IW)) i_qual (
    .ack_slot_i (ack_slot_i),
    .frame_ok_i (frame_ok_i),
    .buf_idx_i  (buf_idx_i),
    .sync_en_i  (sync_en_i),
    .take_o     (take),
    .clear_o    (clear)
  );

  stamp_counter #(.W(W)) i_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (bit_tick_i),
    .clear_i (clear),
    .cnt_o   (count_o)
  );

  stamp_capture #(.W(W), .IW(IW)) i_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (take),
    .idx_i  (buf_idx_i),
    .cnt_i  (count_o),
    .we_o   (cap_we_o),
    .idx_o  (cap_idx_o),
    .data_o (cap_data_o)
  );
endmodule

// File: rtl/stamp_timer_chk.sv
module stamp_timer_chk #(
  parameter int unsigned W  = 16,
  parameter int unsigned IW = 4,
  parameter int unsigned NB = 15
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bit_tick_i,
  input logic          ack_slot_i,
  input logic          frame_ok_i,
  input logic [IW-1:0] buf_idx_i,
  input logic          sync_en_i,
  input logic [W-1:0]  count_o,
  input logic          cap_we_o,
  input logic [IW-1:0] cap_idx_o,
  input logic [W-1:0]  cap_data_o
);
  logic good, sync0;
  assign good  = ack_slot_i && frame_ok_i && (int'(buf_idx_i) < NB);
  assign sync0 = good && sync_en_i && (buf_idx_i == '0);

  always_comb begin
    if (!rst_ni) begin
      a_reset_r1: assert (count_o == '0 && !cap_we_o);
    end
  end

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_tick_i && !sync0) |=> count_o == W'($past(count_o) + 1'b1));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_tick_i && !sync0) |=> $stable(count_o));

  p_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good |=> (cap_we_o && cap_idx_o == $past(buf_idx_i) && cap_data_o == $past(count_o)));

  p_no_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !good |=> !cap_we_o);

  p_sync_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync0 |=> count_o == '0);
endmodule

bind bit_stamp_timer stamp_timer_chk #(.W(W), .IW(IW), .NB(NB)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bit_tick_i (bit_tick_i),
  .ack_slot_i (ack_slot_i),
  .frame_ok_i (frame_ok_i),
  .buf_idx_i  (buf_idx_i),
  .sync_en_i  (sync_en_i),
  .count_o    (count_o),
  .cap_we_o   (cap_we_o),
  .cap_idx_o  (cap_idx_o),
  .cap_data_o (cap_data_o)
);

// File: tb/test_bit_stamp_timer.sv
module test_bit_stamp_timer;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NB = 15;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bit_tick_i = 1'b0, ack_slot_i = 1'b0, frame_ok_i = 1'b0, sync_en_i = 1'b0;
  logic [3:0]  buf_idx_i = '0;
  logic [15:0] count_o, cap_data_o;
  logic        cap_we_o;
  logic [3:0]  cap_idx_o;

  bit_stamp_timer i_bit_stamp_timer (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  typedef struct {
    int          cyc;
    logic [3:0]  idx;
    logic [15:0] data;
    string       req;
  } item_t;

  item_t       exp_q[$];
  int          n_chk = 0, n_bad = 0, cyc = 0;
  logic [15:0] model = '0;
  string       phase = "R2";
  bit          run = 1'b0, done = 1'b0;

  always @(posedge clk_i) cyc++;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected write
  task automatic step(input bit tick, input bit ack, input bit ok,
                      input logic [3:0] idx, input bit sync, input string req);
    logic [15:0] nxt;
    @(negedge clk_i);
    bit_tick_i = tick; ack_slot_i = ack; frame_ok_i = ok;
    buf_idx_i = idx; sync_en_i = sync;
    if (ack && ok && int'(idx) < NB)
      exp_q.push_back('{cyc: cyc, idx: idx, data: model, req: req});
    if (ack && ok && int'(idx) < NB && sync && idx == 0) nxt = '0;
    else if (tick) nxt = model + 1'b1;
    else nxt = model;
    @(posedge clk_i);
    model = nxt;
  endtask

  // monitor: compares count and capture writes at each falling edge
  always @(negedge clk_i) begin
    if (run) begin
      check(count_o == model, phase, "count", count_o, model);
      if (exp_q.size() > 0 && exp_q[0].cyc + 1 == cyc) begin
        check(cap_we_o == 1'b1, exp_q[0].req, "write strobe", cap_we_o, 1);
        check(cap_idx_o == exp_q[0].idx, exp_q[0].req, "write index", cap_idx_o, exp_q[0].idx);
        check(cap_data_o == exp_q[0].data, exp_q[0].req, "write data", cap_data_o, exp_q[0].data);
        void'(exp_q.pop_front());
      end else if (exp_q.size() > 0 && exp_q[0].cyc + 1 < cyc) begin
        check(1'b0, exp_q[0].req, "missing write", 0, 1);
        void'(exp_q.pop_front());
      end else begin
        check(cap_we_o == 1'b0, "R5/R9", "unexpected write", cap_we_o, 0);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual expired expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(count_o == 0, "R1", "count in reset", count_o, 0);
    check(cap_we_o == 0, "R1", "write in reset", cap_we_o, 0);
    bit_tick_i = 1'b1;
    @(negedge clk_i);
    check(count_o == 0, "R1", "count held by reset", count_o, 0);
    bit_tick_i = 1'b0;
    rst_ni = 1'b1;
    run = 1'b1;

    phase = "R2";
    for (int i = 0; i < 40; i++) step(i % 3 != 1, 0, 0, 0, 0, "R2");
    step(1, 1, 1, 4'd5, 1, "R4");   // tick in same cycle: stamp is pre-tick
    step(0, 1, 1, 4'd14, 0, "R4");
    step(1, 0, 0, 0, 0, "R4");
    phase = "R5";
    step(1, 1, 0, 4'd2, 0, "R5");
    step(0, 1, 0, 4'd0, 1, "R5");
    step(1, 0, 0, 0, 0, "R5");
    phase = "R7";
    step(1, 1, 1, 4'd0, 0, "R7");
    step(1, 0, 0, 0, 0, "R7");
    phase = "R6";
    step(1, 1, 1, 4'd0, 1, "R6");
    step(0, 0, 0, 0, 1, "R6");
    check(count_o == 0, "R6", "count after sync clear", count_o, 0);
    for (int i = 0; i < 7; i++) step(1, 0, 0, 0, 1, "R6");
    step(0, 1, 1, 4'd6, 1, "R6");   // stamp measured from new origin
    phase = "R8";
    step(1, 1, 1, 4'd3, 1, "R8");
    step(1, 1, 1, 4'd1, 1, "R8");
    step(0, 0, 0, 0, 0, "R8");
    phase = "R9";
    step(1, 1, 1, 4'd15, 1, "R9");
    step(1, 0, 0, 0, 0, "R9");
    phase = "R3";
    while (model != 16'hFFFE) step(1, 0, 0, 0, 0, "R3");
    step(1, 1, 1, 4'd9, 0, "R3");   // stamp 0xFFFE
    step(1, 1, 1, 4'd8, 0, "R3");   // stamp 0xFFFF, wraps
    step(0, 0, 0, 0, 0, "R3");
    check(count_o == 0, "R3", "count after wrap", count_o, 0);
    step(1, 1, 1, 4'd7, 0, "R3");
    step(1, 1, 1, 4'd0, 1, "R6");
    repeat (3) step(0, 0, 0, 0, 0, "R2");
    check(exp_q.size() == 0, "R4", "queue drained", exp_q.size(), 0);
    finish_run();
  end
endmodule